// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block gives two independently clocked ports a pair of 36-bit single-word message slots that sit beside a data FIFO and skip it. The first slot carries a word from port A to port B. The second slot carries a word from port B to port A. Each slot has an active-low "holds unread mail" flag. The flag is owned by the writing side's clock domain. A write to a slot that still holds unread mail is refused. A read from the other side releases the slot through a toggle handshake, so each read releases the slot once.

Port A selects a slot access with a dedicated select input. Port B selects one by driving both bits of its size field high. Every word is treated as four 9-bit bytes, and the top bit of each byte is its parity bit. A slot read can optionally replace the four parity bits with freshly computed odd or even parity. Each port also reports whether the bytes on its input bus fail the selected parity. During a slot read with generation enabled, that error report is forced to "no error".

Top module: `mbx_pair`

## Requirements
- R1: After reset both slot flags (`m1_full_n`, `m2_full_n`) are high and both read data outputs are zero.
- R2: A port A write with `a_en`=1, `a_wr`=1, `a_mbx`=1 and `m1_full_n` high stores `a_din` in slot 1 and drives `m1_full_n` low from the same `clk_a` edge.
- R3: While `m1_full_n` is low, port A writes to slot 1 are ignored and the stored word is kept. While `m2_full_n` is low, port B writes to slot 2 are ignored in the same way.
- R4: A port B read with `b_en`=1, `b_wr`=0 and `b_size`=2'b11 loads slot 1 into `b_dout` on that `clk_b` edge. It also returns `m1_full_n` high on the third `clk_a` edge after that read edge, and the flag stays high afterwards.
- R5: A port B write with `b_en`=1, `b_wr`=1, `b_size`=2'b11 and `m2_full_n` high stores `b_din` in slot 2 and drives `m2_full_n` low on that `clk_b` edge.
- R6: A port A read with `a_en`=1, `a_wr`=0 and `a_mbx`=1 loads slot 2 into `a_dout`. It also returns `m2_full_n` high on the third `clk_b` edge after the read edge.
- R7: Port A accesses with `a_mbx`=0, and port B accesses with `b_size` other than 2'b11, change neither slot, neither flag, nor either data output.
- R8: Bytes sit at bits [8:0], [17:9], [26:18] and [35:27], with bits 8, 17, 26 and 35 as parity bits. When a slot read has parity generation enabled (`a_pgen` or `b_pgen` = 1), each parity bit of the output is replaced so that the byte has an odd count of ones when `odd_sel`=1 and an even count when `odd_sel`=0. The other 32 bits pass unchanged. Without generation the stored word is output as is.
- R9: Outside a slot read with generation, a port's `*_perr_n` is low exactly when at least one byte of that port's `*_din` has a ones count that does not match the parity chosen by `odd_sel`.
- R10: During a port A slot-2 read with `a_pgen`=1, `a_perr_n` is high whatever `a_din` holds. During a port B slot-1 read with `b_pgen`=1, `b_perr_n` is high in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even |
| clk_a | input | 1 | Port A clock |
| a_en | input | 1 | Port A access enable |
| a_wr | input | 1 | Port A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port A slot access select |
| a_pgen | input | 1 | Port A parity generation on slot reads |
| a_din | input | 36 | Port A input bus |
| a_dout | output | 36 | Port A slot read data (slot 2) |
| a_perr_n | output | 1 | Port A parity error, active low |
| m1_full_n | output | 1 | Slot 1 unread flag, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| b_en | input | 1 | Port B access enable |
| b_wr | input | 1 | Port B direction: 1 write, 0 read |
| b_size | input | 2 | Port B size field; 2'b11 selects the slots |
| b_pgen | input | 1 | Port B parity generation on slot reads |
| b_din | input | 36 | Port B input bus |
| b_dout | output | 36 | Port B slot read data (slot 1) |
| b_perr_n | output | 1 | Port B parity error, active low |
| m2_full_n | output | 1 | Slot 2 unread flag, active low, clk_b domain |

## Verification
Slot traffic runs as a random mix of writes and reads in both directions, interleaved with accesses that are not slot accesses. The random mix tells accepted writes apart from locked-out writes, and shows whether a stale read releases a flag twice. Reads are tried with generation off and with generation under both parity senses. Payloads with all-zero, all-one and random bytes distinguish parity replacement from pass-through of the data bits. The parity-error outputs are checked on random buses with zero, one or several corrupted bytes, both outside slot reads and during generating reads, where the override must hide the error.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int BYTES_DEF  = 4;
  localparam int BYTE_W_DEF = 9;
  localparam logic [1:0] B_SIZE_MBX = 2'b11;

  function automatic logic b_slot_hit(input logic [1:0] size);
    return size == B_SIZE_MBX;
  endfunction
endpackage

// File: rtl/mbx_toggle_sync.sv
module mbx_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic rst_n,
  input  logic src_clk,
  input  logic src_evt,
  input  logic dst_clk,
  output logic dst_evt
);
  localparam int SH = STAGES + 1;

  logic          tog_q;
  logic [SH-1:0] sh_q;

  always_ff @(posedge src_clk or negedge rst_n)
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_q ^ src_evt;

  always_ff @(posedge dst_clk or negedge rst_n)
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH-2:0], tog_q};

  assign dst_evt = sh_q[SH-1] ^ sh_q[SH-2];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_req,
  input  logic [W-1:0] din,
  input  logic         rel_evt,
  output logic         full_n,
  output logic [W-1:0] data
);
  logic wr_take;
  assign wr_take = wr_req && full_n;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      full_n <= 1'b1;
      data   <= '0;
    end else begin
      if (wr_take) begin
        data   <= din;
        full_n <= 1'b0;
      end else if (rel_evt) begin
        full_n <= 1'b1;
      end
    end

  a_r2_set_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && full_n |=> !full_n && data == $past(din));
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n && !rel_evt |=> !full_n && $stable(data));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt && !(wr_req && full_n) |=> full_n);
  a_r7_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> $stable(data));
endmodule

// File: rtl/mbx_port_parity.sv
module mbx_port_parity #(
  parameter int BYTES  = 4,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd,
  input  logic                    gen,
  input  logic                    odd,
  input  logic [BYTES*BYTE_W-1:0] slot,
  input  logic [BYTES*BYTE_W-1:0] din,
  output logic [BYTES*BYTE_W-1:0] dout,
  output logic                    perr_n
);
  localparam int W = BYTES * BYTE_W;

  function automatic logic [W-1:0] fill_par(input logic [W-1:0] d, input logic o);
    logic [W-1:0] r;
    r = d;
    for (int i = 0; i < BYTES; i++)
      r[i*BYTE_W + BYTE_W-1] = (^d[i*BYTE_W +: BYTE_W-1]) ^ o;
    return r;
  endfunction

  function automatic logic any_bad(input logic [W-1:0] d, input logic o);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < BYTES; i++)
      bad |= ((^d[i*BYTE_W +: BYTE_W]) != o);
    return bad;
  endfunction

  logic gen_rd;
  logic din_bad;
  assign gen_rd  = rd && gen;
  assign din_bad = any_bad(din, odd);
  assign perr_n  = gen_rd ? 1'b1 : !din_bad;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  dout <= '0;
    else if (rd) dout <= gen ? fill_par(slot, odd) : slot;

  a_r8_gen_parity_ok: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rd |=> !any_bad(dout, $past(odd)));
  a_r10_perr_forced: assert property (@(posedge clk) disable iff (!rst_n)
    gen_rd |-> perr_n);
  a_r7_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(dout));
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
  import mbx_pkg::*;
#(
  parameter int BYTES       = BYTES_DEF,
  parameter int BYTE_W      = BYTE_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    rst_n,
  input  logic                    odd_sel,
  input  logic                    clk_a,
  input  logic                    a_en,
  input  logic                    a_wr,
  input  logic                    a_mbx,
  input  logic                    a_pgen,
  input  logic [BYTES*BYTE_W-1:0] a_din,
  output logic [BYTES*BYTE_W-1:0] a_dout,
  output logic                    a_perr_n,
  output logic                    m1_full_n,
  input  logic                    clk_b,
  input  logic                    b_en,
  input  logic                    b_wr,
  input  logic [1:0]              b_size,
  input  logic                    b_pgen,
  input  logic [BYTES*BYTE_W-1:0] b_din,
  output logic [BYTES*BYTE_W-1:0] b_dout,
  output logic                    b_perr_n,
  output logic                    m2_full_n
);
  localparam int W = BYTES * BYTE_W;

  logic         a_slot_wr, a_slot_rd, b_slot_wr, b_slot_rd;
  logic         m1_rel_a, m2_rel_b;
  logic [W-1:0] m1_data, m2_data;

  assign a_slot_wr = a_en &&  a_wr && a_mbx;
  assign a_slot_rd = a_en && !a_wr && a_mbx;
  assign b_slot_wr = b_en &&  b_wr && b_slot_hit(b_size);
  assign b_slot_rd = b_en && !b_wr && b_slot_hit(b_size);

  mbx_slot #(.W(W)) u_m1 (
    .clk(clk_a), .rst_n(rst_n), .wr_req(a_slot_wr), .din(a_din),
    .rel_evt(m1_rel_a), .full_n(m1_full_n), .data(m1_data));

  mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_m1_rel (
    .rst_n(rst_n), .src_clk(clk_b), .src_evt(b_slot_rd),
    .dst_clk(clk_a), .dst_evt(m1_rel_a));

  mbx_slot #(.W(W)) u_m2 (
    .clk(clk_b), .rst_n(rst_n), .wr_req(b_slot_wr), .din(b_din),
    .rel_evt(m2_rel_b), .full_n(m2_full_n), .data(m2_data));

  mbx_toggle_sync #(.STAGES(SYNC_STAGES)) u_m2_rel (
    .rst_n(rst_n), .src_clk(clk_a), .src_evt(a_slot_rd),
    .dst_clk(clk_b), .dst_evt(m2_rel_b));

  mbx_port_parity #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_par_a (
    .clk(clk_a), .rst_n(rst_n), .rd(a_slot_rd), .gen(a_pgen), .odd(odd_sel),
    .slot(m2_data), .din(a_din), .dout(a_dout), .perr_n(a_perr_n));

  mbx_port_parity #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_par_b (
    .clk(clk_b), .rst_n(rst_n), .rd(b_slot_rd), .gen(b_pgen), .odd(odd_sel),
    .slot(m1_data), .din(b_din), .dout(b_dout), .perr_n(b_perr_n));

  a_r3_m1_write_blocked: assert property (@(posedge clk_a) disable iff (!rst_n)
    a_slot_wr && !m1_full_n && !m1_rel_a |=> !m1_full_n && $stable(m1_data));
  a_r5_m2_set: assert property (@(posedge clk_b) disable iff (!rst_n)
    b_slot_wr && m2_full_n |=> !m2_full_n);
endmodule

// File: tb/mbx_pair_tb.sv
module mbx_pair_tb;
  localparam int W = 36;

  logic rst_n = 0, odd_sel = 0;
  logic clk_a = 0, clk_b = 0;
  logic a_en = 0, a_wr = 0, a_mbx = 0, a_pgen = 0;
  logic b_en = 0, b_wr = 0, b_pgen = 0;
  logic [1:0] b_size = 0;
  logic [W-1:0] a_din = 0, b_din = 0;
  logic [W-1:0] a_dout, b_dout;
  logic a_perr_n, b_perr_n, m1_full_n, m2_full_n;

  int checks = 0, fails = 0;
  logic [W-1:0] e_m1 = 0, e_m2 = 0, e_ad = 0, e_bd = 0;
  logic e_f1 = 1, e_f2 = 1;

  mbx_pair u_dut (
    .rst_n(rst_n), .odd_sel(odd_sel),
    .clk_a(clk_a), .a_en(a_en), .a_wr(a_wr), .a_mbx(a_mbx), .a_pgen(a_pgen),
    .a_din(a_din), .a_dout(a_dout), .a_perr_n(a_perr_n), .m1_full_n(m1_full_n),
    .clk_b(clk_b), .b_en(b_en), .b_wr(b_wr), .b_size(b_size), .b_pgen(b_pgen),
    .b_din(b_din), .b_dout(b_dout), .b_perr_n(b_perr_n), .m2_full_n(m2_full_n));

  always #4 clk_a = ~clk_a;
  initial begin #2; forever #4 clk_b = ~clk_b; end

  function automatic logic [W-1:0] exp_fill(input logic [W-1:0] d, input logic o);
    logic [W-1:0] r = d;
    for (int k = 0; k < 4; k++)
      r[9*k+8] = ($countones(d[9*k +: 8]) % 2 == 0) ? o : !o;
    return r;
  endfunction

  function automatic logic exp_err(input logic [W-1:0] d, input logic o);
    for (int k = 0; k < 4; k++)
      if (($countones(d[9*k +: 9]) % 2) != int'(o)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk(m1_full_n == e_f1, {tag, " R2 R4 m1 flag"}, W'(m1_full_n), W'(e_f1));
    chk(m2_full_n == e_f2, {tag, " R5 R6 m2 flag"}, W'(m2_full_n), W'(e_f2));
    chk(a_dout == e_ad, {tag, " R6 a_dout"}, a_dout, e_ad);
    chk(b_dout == e_bd, {tag, " R4 b_dout"}, b_dout, e_bd);
  endtask

  task automatic wait_a(input int n); repeat (n) @(negedge clk_a); endtask
  task automatic wait_b(input int n); repeat (n) @(negedge clk_b); endtask

  task automatic a_write(input logic [W-1:0] d, input logic mbx);
    @(negedge clk_a);
    a_en = 1; a_wr = 1; a_mbx = mbx; a_din = d;
    @(negedge clk_a);
    a_en = 0;
    if (mbx && e_f1) begin e_m1 = d; e_f1 = 0; end
    chk(m1_full_n == e_f1, "R2 R3 R7 m1 flag after write", W'(m1_full_n), W'(e_f1));
  endtask

  task automatic b_write(input logic [W-1:0] d, input logic [1:0] sz);
    @(negedge clk_b);
    b_en = 1; b_wr = 1; b_size = sz; b_din = d;
    @(negedge clk_b);
    b_en = 0;
    if (sz == 2'b11 && e_f2) begin e_m2 = d; e_f2 = 0; end
    chk(m2_full_n == e_f2, "R5 R3 R7 m2 flag after write", W'(m2_full_n), W'(e_f2));
  endtask

  task automatic b_read(input logic gen, input logic o, input logic [1:0] sz);
    @(negedge clk_b);
    odd_sel = o; b_en = 1; b_wr = 0; b_size = sz; b_pgen = gen;
    b_din = $urandom; b_din[35:32] = $urandom;
    #1;
    if (sz == 2'b11 && gen)
      chk(b_perr_n == 1'b1, "R10 b_perr_n forced", W'(b_perr_n), W'(1));
    else
      chk(b_perr_n == !exp_err(b_din, o), "R9 b_perr_n", W'(b_perr_n), W'(!exp_err(b_din, o)));
    @(negedge clk_b);
    b_en = 0; b_pgen = 0;
    if (sz == 2'b11) e_bd = gen ? exp_fill(e_m1, o) : e_m1;
    chk(b_dout == e_bd, "R4 R8 R7 b_dout", b_dout, e_bd);
    if (sz == 2'b11) begin
      wait_a(1);
      chk(m1_full_n == e_f1, "R4 m1 flag not early", W'(m1_full_n), W'(e_f1));
      wait_a(4);
      e_f1 = 1;
      chk(m1_full_n == 1'b1, "R4 m1 released", W'(m1_full_n), W'(1));
    end
  endtask

  task automatic a_read(input logic gen, input logic o, input logic mbx);
    @(negedge clk_a);
    odd_sel = o; a_en = 1; a_wr = 0; a_mbx = mbx; a_pgen = gen;
    a_din = $urandom; a_din[35:32] = $urandom;
    #1;
    if (mbx && gen)
      chk(a_perr_n == 1'b1, "R10 a_perr_n forced", W'(a_perr_n), W'(1));
    else
      chk(a_perr_n == !exp_err(a_din, o), "R9 a_perr_n", W'(a_perr_n), W'(!exp_err(a_din, o)));
    @(negedge clk_a);
    a_en = 0; a_pgen = 0;
    if (mbx) e_ad = gen ? exp_fill(e_m2, o) : e_m2;
    chk(a_dout == e_ad, "R6 R8 R7 a_dout", a_dout, e_ad);
    if (mbx) begin
      wait_b(1);
      chk(m2_full_n == e_f2, "R6 m2 flag not early", W'(m2_full_n), W'(e_f2));
      wait_b(4);
      e_f2 = 1;
      chk(m2_full_n == 1'b1, "R6 m2 released", W'(m2_full_n), W'(1));
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    wait_a(3);
    rst_n = 1;
    wait_a(2);
    chk_all("R1 reset");

    // directed corners
    a_write(36'h0_0000_0000, 1);
    a_write(36'hF_FFFF_FFFF, 1);           // R3: locked out
    b_read(1, 1, 2'b11);                   // R8 all-zero payload odd
    a_write(36'hF_FFFF_FFFF, 1);
    b_read(1, 0, 2'b11);                   // R8 all-one payload even
    b_read(0, 1, 2'b11);                   // stale read, no generation
    b_write(36'h1_2345_6789, 2'b11);
    b_write(36'hA_AAAA_AAAA, 2'b11);       // R3 on slot 2
    b_write(36'h5_5555_5555, 2'b01);       // R7 non-slot size
    a_write(36'h3_3333_3333, 0);           // R7 non-slot write, but slot 1 empty
    a_read(0, 0, 0);                       // R7 non-slot read
    chk_all("R7 after non-slot access");
    a_read(1, 1, 1);
    b_read(0, 0, 2'b10);                   // R7 non-slot read on B

    // parity error with clean and corrupted bytes while idle
    for (int i = 0; i < 12; i++) begin
      logic o = i[0];
      logic [W-1:0] d = exp_fill({$urandom, 4'($urandom)}, o);
      if (i % 3 == 1) d[9*(i%4) + 2] ^= 1'b1;
      if (i % 3 == 2) begin d[3] ^= 1'b1; d[30] ^= 1'b1; end
      @(negedge clk_a); odd_sel = o; a_din = d; b_din = d; #1;
      chk(a_perr_n == !exp_err(d, o), "R9 a_perr_n idle", W'(a_perr_n), W'(!exp_err(d, o)));
      chk(b_perr_n == !exp_err(d, o), "R9 b_perr_n idle", W'(b_perr_n), W'(!exp_err(d, o)));
    end

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 5);
      logic [W-1:0] d = {$urandom, 4'($urandom)};
      case (op)
        0: a_write(d, 1);
        1: b_read(1'($urandom), 1'($urandom), 2'b11);
        2: b_write(d, 2'b11);
        3: a_read(1'($urandom), 1'($urandom), 1);
        4: a_write(d, 0);
        default: b_write(d, 2'($urandom_range(0, 2)));
      endcase
    end
    chk_all("R2 R5 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule